// File: doc/BRIEF.md
# Two-Requester Fixed-Priority Arbiter with Grant Hold

This block arbitrates between two requesters. It samples both request inputs on every rising clock edge and registers the decision, so a grant appears one cycle after the request that caused it. The high-priority requester always wins. A grant is issued as a pulse of `HOLD_CYCLES` cycles, two by default. If the same requester is sampled high again while its grant is still up, the window restarts.

A high-priority request also preempts a low-priority grant that is in progress. The low grant drops on the next cycle and the rest of its window is lost. A low-priority request that arrives while the high grant is up is not stored. The low requester must keep asserting until it is sampled at a time when the high grant is down and there is no high request. At most one grant is ever high.

Top module: `prio2_hold_arb`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both grants are low in the following cycle, and both hold windows are cleared.
- R2: When `req_hi` is sampled high, `gnt_hi` is high in the next cycle.
- R3: `gnt_hi` stays high for exactly `HOLD_CYCLES` (2) cycles, counted from the most recent `req_hi` sample. A new sample during the window restarts the count. After the window ends with no new sample, `gnt_hi` is low.
- R4: When `req_lo` is sampled high with `req_hi` low and `gnt_hi` low, `gnt_lo` is high for the next `HOLD_CYCLES` (2) cycles, unless `req_hi` preempts it.
- R5: A `req_lo` sample taken while `gnt_hi` is high (and `req_hi` low) is ignored. `gnt_lo` stays low in the next cycle, and the request is not granted later unless it is sampled again.
- R6: When `req_hi` is sampled high while `gnt_lo` is high, the next cycle shows `gnt_hi` high and `gnt_lo` low. The remaining low window is cancelled.
- R7: When `req_lo` is sampled high while `gnt_lo` is held (and `req_hi` low), `gnt_lo` stays high for `HOLD_CYCLES` cycles counted from the new sample.
- R8: `gnt_hi` and `gnt_lo` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_hi | input | 1 | Request from the high-priority requester |
| req_lo | input | 1 | Request from the low-priority requester |
| gnt_hi | output | 1 | Grant to the high-priority requester |
| gnt_lo | output | 1 | Grant to the low-priority requester |

## Verification
The hardest case to reach is the interaction at the edge of a window. Examples are a low request landing on the last cycle of a high grant, where it is still dropped, and a high request landing in the middle of a low grant. The bench reaches these with directed request sequences timed one cycle apart, then with a long stretch of random request pairs that includes a mid-run reset. A behavioural model that sees only the request history predicts both grants on every cycle.

// File: rtl/prio2_arb_pkg.sv
package prio2_arb_pkg;
    localparam int NREQ = 2;

    typedef enum int {
        SLOT_HI = 0,
        SLOT_LO = 1
    } slot_e;
endpackage

// File: rtl/prio2_pick.sv
module prio2_pick
    import prio2_arb_pkg::*;
(
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] busy_i,
    output logic [NREQ-1:0] load_o,
    output logic [NREQ-1:0] clear_o
);
    always_comb begin
        load_o  = '0;
        clear_o = '0;
        // high requester always restarts its own window
        load_o[SLOT_HI]  = req_i[SLOT_HI];
        // low requester only when the high side is idle and silent
        load_o[SLOT_LO]  = req_i[SLOT_LO] & ~req_i[SLOT_HI] & ~busy_i[SLOT_HI];
        // high request cancels any low window in progress
        clear_o[SLOT_LO] = req_i[SLOT_HI];
    end
endmodule

// File: rtl/prio2_hold_ctr.sv
module prio2_hold_ctr #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic clear_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    typedef struct packed {
        logic [CW-1:0] left;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.left = '0;
        end else if (load_i) begin
            st_d.left = HOLD_V;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.left != '0);
endmodule

// File: rtl/prio2_hold_arb.sv
module prio2_hold_arb
    import prio2_arb_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic gnt_hi,
    output logic gnt_lo
);
    logic [NREQ-1:0] req_v;
    logic [NREQ-1:0] busy_v;
    logic [NREQ-1:0] load_v;
    logic [NREQ-1:0] clear_v;

    always_comb begin
        req_v          = '0;
        req_v[SLOT_HI] = req_hi;
        req_v[SLOT_LO] = req_lo;
    end

    prio2_pick u_pick (
        .req_i   (req_v),
        .busy_i  (busy_v),
        .load_o  (load_v),
        .clear_o (clear_v)
    );

    for (genvar gi = 0; gi < NREQ; gi++) begin : g_slot
        prio2_hold_ctr #(.HOLD(HOLD_CYCLES)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_v[gi]),
            .clear_i (clear_v[gi]),
            .busy_o  (busy_v[gi])
        );
    end

    assign gnt_hi = busy_v[SLOT_HI];
    assign gnt_lo = busy_v[SLOT_LO];
endmodule

// File: rtl/prio2_hold_arb_chk.sv
module prio2_hold_arb_chk #(
    parameter int HOLD = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_hi,
    input logic req_lo,
    input logic gnt_hi,
    input logic gnt_lo
);
    // support counter built from the high request history only
    int unsigned hi_left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_left_q <= 0;
        end else if (req_hi) begin
            hi_left_q <= HOLD;
        end else if (hi_left_q != 0) begin
            hi_left_q <= hi_left_q - 1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!gnt_hi && !gnt_lo));

    assert_hi_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_hi |=> gnt_hi);

    assert_hi_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_hi == (hi_left_q != 0));

    assert_lo_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lo && !req_hi && !gnt_hi) |=> gnt_lo);

    assert_lo_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lo && !req_hi && gnt_hi) |=> !gnt_lo);

    assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hi && gnt_lo) |=> (gnt_hi && !gnt_lo));

    assert_lo_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lo && !req_hi && gnt_lo) |=> gnt_lo);

    assert_mutex_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gnt_hi, gnt_lo}) <= 1);
endmodule

bind prio2_hold_arb prio2_hold_arb_chk #(.HOLD(HOLD_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_hi (req_hi),
    .req_lo (req_lo),
    .gnt_hi (gnt_hi),
    .gnt_lo (gnt_lo)
);

// File: tb/prio2_hold_arb_test.sv
`timescale 1ns/1ps
module prio2_hold_arb_test;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_hi = 1'b0;
    logic req_lo = 1'b0;
    logic gnt_hi, gnt_lo;

    int tests = 0;
    int fails = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // reference model state: remaining grant cycles per requester
    int hi_left = 0;
    int lo_left = 0;

    always #10 clk = ~clk;   // 50 MHz

    prio2_hold_arb #(.HOLD_CYCLES(HOLD)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_hi (req_hi),
        .req_lo (req_lo),
        .gnt_hi (gnt_hi),
        .gnt_lo (gnt_lo)
    );

    always @(posedge clk) begin
        int hi_was;
        hi_was  = hi_left;
        exp_tag = cur_tag;
        if (!rst_n) begin
            hi_left = 0;
            lo_left = 0;
        end else if (req_hi) begin
            hi_left = HOLD;
            lo_left = 0;
        end else begin
            if (hi_left > 0) hi_left--;
            if (req_lo && hi_was == 0) lo_left = HOLD;
            else if (lo_left > 0) lo_left--;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        logic e_hi, e_lo;
        e_hi = (hi_left > 0);
        e_lo = (lo_left > 0);
        tests++;
        if (gnt_hi !== e_hi || gnt_lo !== e_lo) begin
            fails++;
            $display("FAIL %s: gnt_hi/gnt_lo = %b%b expected %b%b at %0t",
                     exp_tag, gnt_hi, gnt_lo, e_hi, e_lo, $time);
        end
        tests++;
        if (gnt_hi === 1'b1 && gnt_lo === 1'b1) begin
            fails++;
            $display("FAIL R8: both grants high, got 11 expected at most one at %0t", $time);
        end
    end

    task automatic step(input logic hi, input logic lo, input string tag);
        @(negedge clk);
        #1;
        cur_tag = tag;
        req_hi  = hi;
        req_lo  = lo;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
    endtask

    task automatic expect_pair(input logic hi, input logic lo, input string tag);
        @(negedge clk);
        #2;
        tests++;
        if (gnt_hi !== hi || gnt_lo !== lo) begin
            fails++;
            $display("FAIL %s: directed got %b%b expected %b%b", tag, gnt_hi, gnt_lo, hi, lo);
        end
    endtask

    initial begin
        int unsigned seed;
        // R1: reset with requests active
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        expect_pair(1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1");
        idle(3, "R1");

        // R2/R3: single high pulse gives exactly two cycles
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, "R3");
        idle(4, "R3");
        // R3: restart during window
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, "R3");
        idle(4, "R3");

        // R4: low pulse
        step(1'b0, 1'b1, "R4");
        idle(4, "R4");

        // R5: low request while high grant in first and last cycle
        step(1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R5");
        expect_pair(1'b0, 1'b0, "R5");
        idle(3, "R5");

        // R6: preemption mid low window
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
        expect_pair(1'b1, 1'b0, "R6");
        idle(4, "R6");

        // R7: low restart
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R7");
        expect_pair(1'b0, 1'b1, "R7");
        idle(4, "R7");

        // R8: random traffic with a mid-run reset
        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (i == 300) begin
                @(negedge clk);
                #1;
                cur_tag = "R1";
                rst_n = 1'b0;
            end else if (i == 302) begin
                @(negedge clk);
                #1;
                rst_n = 1'b1;
            end else begin
                step(seed[20] & seed[17], seed[24], "R8");
            end
        end
        idle(4, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule